// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data on behalf of two independent channels by borrowing the system bus for one read followed by one write, then handing it back. Each accepted request moves exactly one unit, either a byte or a 16-bit word, across a 20-bit address space. Per channel, software sets a source address, a destination address, a 16-bit count reload value and a control word. The control word holds the enable, the single or repeat mode, the unit size and a forward/fixed choice for each address.

Requests reach the block already selected and edge-qualified, as one strobe per channel. A strobe is latched as pending while the channel is enabled. Pending channels are served one at a time, and channel 0 wins when both wait. When a channel's count runs out it pulses its interrupt line. A single-mode channel then switches itself off. A repeat-mode channel reloads its count and carries on.

Top module: `dmac_top`

## Requirements
- R1: When both channels are pending in the same idle cycle, channel 0 is served first and channel 1 follows.
- R2: Each served request produces exactly one granted read cycle (`bus_wr`=0, address = source) followed by exactly one granted write cycle (`bus_wr`=1, address = destination). `bus_req` then drops for at least one cycle.
- R3: Control bit 2 selects the unit. 1 means a 16-bit word: `bus_word`=1 and all 16 read bits are written. 0 means a byte: bits [7:0] of the read data are written and bits [15:8] of `bus_wdata` are zero.
- R4: A forward address advances after each transfer by 1 for a byte and by 2 for a word, wrapping modulo 2^20. A fixed address never changes. Control bit 3 makes the source forward and bit 4 makes the destination forward.
- R5: A control write with both bit 3 and bit 4 set is discarded entirely, and the control register keeps its previous value.
- R6: In single mode (control bit 1 = 0), a channel whose reload value is N performs N+1 transfers. It then clears its enable bit (control bit 0), and its counter reads 0xFFFF.
- R7: In repeat mode (control bit 1 = 1), the transfer that underflows reloads the counter from the reload register, and the enable bit stays set.
- R8: Every counter underflow raises that channel's `dma_irq` bit for exactly one cycle, starting the cycle after the completing write.
- R9: The first transfer after the enable bit goes from 0 to 1 takes the forward address from the programmed register and the count from the reload register, whatever the channel did before.
- R10: Request strobes that arrive while the channel's enable bit is 0 cause no bus activity.
- R11: Strobes that arrive while a transfer is in progress are held as one pending request. Any number of them before service yields a single further transfer.
- R12: Register map: `reg_addr[3]` selects the channel, and `reg_addr[2:0]` selects the field. The fields are 0 source, 1 destination, 2 reload, 3 control and 4 live counter (read only). All fields read as 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel select (bit 3) and field select (bits 2:0) |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data, combinational from `reg_addr` |
| dma_req | input | 2 | Per-channel request strobe |
| bus_req | output | 1 | Bus cycle requested |
| bus_addr | output | 20 | Bus address |
| bus_wr | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_word | output | 1 | 1 for a 16-bit cycle, 0 for a byte |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled in the granted read cycle |
| bus_gnt | input | 1 | Bus grant; the current cycle completes when high |
| dma_irq | output | 2 | Per-channel underflow pulse |

## Verification
The hardest case to reach from the ports is a request that lands while the engine is already busy, and then a second and third request merging into one pending flag. The bench creates this by holding `bus_gnt` low so that the first transfer stalls in its read phase. It strobes the channel twice more, then releases the grant and counts the granted cycles. Re-enabling a channel partway through a block is another hidden case. The bench checks it by comparing the first read address and the live counter after re-enable with the programmed values, not with the values the channel had reached.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } bus_st_e;

    localparam logic [2:0] F_SRC = 3'd0;
    localparam logic [2:0] F_DST = 3'd1;
    localparam logic [2:0] F_RLD = 3'd2;
    localparam logic [2:0] F_CTL = 3'd3;
    localparam logic [2:0] F_CNT = 3'd4;

    // control word, bit 0 is the enable
    typedef struct packed {
        logic dfwd;
        logic sfwd;
        logic word;
        logic rpt;
        logic en;
    } ctl_t;

endpackage

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] pend,
    output logic [NCH-1:0] gnt
);
    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        gnt = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) gnt = NCH'(1) << i;
        end
    end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 16,
    parameter int DW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    field,
    input  logic [DW-1:0] wr_data,
    input  logic          req,
    input  logic          take,
    input  logic          done,
    output logic [DW-1:0] rd_data,
    output logic          pend,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          word,
    output logic          irq
);
    typedef struct packed {
        logic [AW-1:0] src_prog;
        logic [AW-1:0] dst_prog;
        logic [AW-1:0] work;
        logic [CW-1:0] reload;
        logic [CW-1:0] count;
        ctl_t          ctl;
        logic          first;
        logic          pend;
        logic          irq;
    } chan_t;

    chan_t d_d, d_q;
    logic [AW-1:0] cur_fwd;
    logic [CW-1:0] eff;
    logic          under;
    logic          ctl_wr;

    always_comb begin
        cur_fwd = d_q.first ? (d_q.ctl.sfwd ? d_q.src_prog : d_q.dst_prog) : d_q.work;
        eff     = d_q.first ? d_q.reload : d_q.count;
        under   = (eff == '0);
        ctl_wr  = wr_en && (field == F_CTL);

        d_d     = d_q;
        d_d.irq = 1'b0;
        d_d.pend = d_q.ctl.en & ((d_q.pend & ~take) | req);

        if (done) begin
            d_d.first = 1'b0;
            d_d.work  = cur_fwd + (d_q.ctl.word ? AW'(2) : AW'(1));
            d_d.count = eff - CW'(1);
            if (under) begin
                d_d.irq = 1'b1;
                if (d_q.ctl.rpt) d_d.count  = d_q.reload;
                else             d_d.ctl.en = 1'b0;
            end
        end

        if (wr_en) begin
            case (field)
                F_SRC: d_d.src_prog = wr_data[AW-1:0];
                F_DST: d_d.dst_prog = wr_data[AW-1:0];
                F_RLD: d_d.reload   = wr_data[CW-1:0];
                F_CTL: begin
                    if (!(wr_data[4] && wr_data[3])) begin
                        d_d.ctl = ctl_t'(wr_data[4:0]);
                        if (wr_data[0] && !d_q.ctl.en) d_d.first = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    always_comb begin
        case (field)
            F_SRC:   rd_data = DW'(d_q.src_prog);
            F_DST:   rd_data = DW'(d_q.dst_prog);
            F_RLD:   rd_data = DW'(d_q.reload);
            F_CTL:   rd_data = DW'(d_q.ctl);
            F_CNT:   rd_data = DW'(d_q.count);
            default: rd_data = '0;
        endcase
    end

    assign pend     = d_q.pend;
    assign word     = d_q.ctl.word;
    assign irq      = d_q.irq;
    assign src_addr = d_q.ctl.sfwd ? cur_fwd : d_q.src_prog;
    assign dst_addr = d_q.ctl.dfwd ? cur_fwd : d_q.dst_prog;

    a_r5_no_both_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_q.ctl.sfwd && d_q.ctl.dfwd));
    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.irq |=> !d_q.irq);
    a_r6_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (done && under && !d_q.ctl.rpt && !ctl_wr) |=> !d_q.ctl.en);
    a_r7_repeat_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (done && under && d_q.ctl.rpt && !ctl_wr) |=> (d_q.ctl.en && d_q.count == $past(d_q.reload)));
    a_r10_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !d_q.ctl.en |=> !d_q.pend);
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 20,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH),
    localparam int RAW = CHW + 3,
    localparam int DW  = (AW > CW) ? AW : CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] dma_req,
    output logic           bus_req,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_wr,
    output logic           bus_word,
    output logic [15:0]    bus_wdata,
    input  logic [15:0]    bus_rdata,
    input  logic           bus_gnt,
    output logic [NCH-1:0] dma_irq
);
    typedef struct packed {
        bus_st_e       st;
        logic [CHW-1:0] ch;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic          word;
        logic [15:0]   data;
    } eng_t;

    eng_t e_d, e_q;

    logic [NCH-1:0] pend, gnt, take, done;
    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic           word_a [NCH];
    logic [DW-1:0]  rd_a [NCH];
    logic [CHW-1:0] sel;

    dmac_arb #(.NCH(NCH)) u_arb (.pend(pend), .gnt(gnt));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dmac_chan #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && (reg_addr[RAW-1:3] == CHW'(i))),
            .field    (reg_addr[2:0]),
            .wr_data  (reg_wdata),
            .req      (dma_req[i]),
            .take     (take[i]),
            .done     (done[i]),
            .rd_data  (rd_a[i]),
            .pend     (pend[i]),
            .src_addr (src_a[i]),
            .dst_addr (dst_a[i]),
            .word     (word_a[i]),
            .irq      (dma_irq[i])
        );
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NCH; i++) begin
            if (gnt[i]) sel = CHW'(i);
        end
    end

    always_comb begin
        e_d  = e_q;
        take = '0;
        done = '0;
        case (e_q.st)
            ST_IDLE: begin
                if (|pend) begin
                    take     = gnt;
                    e_d.st   = ST_RD;
                    e_d.ch   = sel;
                    e_d.src  = src_a[sel];
                    e_d.dst  = dst_a[sel];
                    e_d.word = word_a[sel];
                end
            end
            ST_RD: begin
                if (bus_gnt) begin
                    e_d.data = e_q.word ? bus_rdata : {8'h00, bus_rdata[7:0]};
                    e_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (bus_gnt) begin
                    done[e_q.ch] = 1'b1;
                    e_d.st       = ST_IDLE;
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign bus_req   = (e_q.st != ST_IDLE);
    assign bus_wr    = (e_q.st == ST_WR);
    assign bus_addr  = (e_q.st == ST_WR) ? e_q.dst : e_q.src;
    assign bus_word  = e_q.word;
    assign bus_wdata = e_q.data;
    assign reg_rdata = rd_a[reg_addr[RAW-1:3]];

    a_r1_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_IDLE && pend[0]) |=> (e_q.st == ST_RD && e_q.ch == '0));
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !bus_wr) |=> (bus_req && bus_wr));
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_wr) |=> !bus_req);
endmodule

// File: tb/sim_dmac_top.sv
module sim_dmac_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [19:0] reg_wdata = '0;
    logic [19:0] reg_rdata;
    logic [1:0]  dma_req = '0;
    logic        bus_req, bus_wr, bus_word;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        bus_gnt = 1'b1;
    logic [1:0]  dma_irq;

    always #2 clk = ~clk;

    // read data derived from the address
    assign bus_rdata = {bus_addr[7:0] ^ 8'hA5, bus_addr[7:0]};

    dmac_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_gnt(bus_gnt), .dma_irq(dma_irq)
    );

    int nrd = 0, nwr = 0, irq0 = 0, irq1 = 0;
    logic [19:0] rd_log [0:63];
    logic [19:0] wr_log [0:63];
    logic [15:0] wd_log [0:63];

    always @(negedge clk) begin
        if (bus_req && bus_gnt) begin
            if (bus_wr) begin
                if (nwr < 64) begin wr_log[nwr] = bus_addr; wd_log[nwr] = bus_wdata; end
                nwr++;
            end else begin
                if (nrd < 64) rd_log[nrd] = bus_addr;
                nrd++;
            end
        end
        if (dma_irq[0]) irq0++;
        if (dma_irq[1]) irq1++;
    end

    int total = 0, fails = 0, cyc = 0;
    bit ended = 0;

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !ended) begin
            total++; fails++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            summary();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [3:0] a, logic [19:0] v);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rreg(logic [3:0] a, output logic [19:0] v);
        @(negedge clk); reg_addr = a; #1 v = reg_rdata;
    endtask

    task automatic pulse(logic [1:0] m);
        @(negedge clk); dma_req = m;
        @(negedge clk); dma_req = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [19:0] src;
        logic [19:0] dst;
        logic [15:0] rld;
        logic [4:0]  ctl;
        logic [3:0]  nreq;
        logic [3:0]  xfers;
        logic [19:0] last_a;
        logic [15:0] last_d;
        logic [15:0] cnt;
        logic        en;
        logic [3:0]  irqs;
    } vec_t;

    // ctl bits: 0 enable, 1 repeat, 2 word, 3 source forward, 4 destination forward
    localparam vec_t VECS [4] = '{
        '{20'h00100, 20'h80000, 16'd2, 5'h09, 4'd3, 4'd3, 20'h80000, 16'h0002, 16'hFFFF, 1'b0, 4'd1},
        '{20'h40000, 20'hFFFFE, 16'd1, 5'h15, 4'd2, 4'd2, 20'h00000, 16'hA500, 16'hFFFF, 1'b0, 4'd1},
        '{20'h00010, 20'h00020, 16'd1, 5'h07, 4'd3, 4'd3, 20'h00020, 16'hB510, 16'h0000, 1'b1, 4'd1},
        '{20'h00203, 20'h00050, 16'd0, 5'h09, 4'd3, 4'd1, 20'h00050, 16'h0003, 16'hFFFF, 1'b0, 4'd1}
    };

    initial begin
        logic [19:0] v;
        int b_rd, b_wr, b_irq;

        idle(2);
        // R12: reset state
        #1 chk("R12 bus_req after reset", 32'(bus_req), 0);
        chk("R8 irq after reset", 32'(dma_irq), 0);
        @(negedge clk); rst_n = 1'b1;
        rreg(4'd3, v); chk("R12 ctl0 reset", 32'(v), 0);
        rreg(4'd8, v); chk("R12 src1 reset", 32'(v), 0);

        // vector walk: R3 R4 R6 R7 R8 R2
        for (int i = 0; i < 4; i++) begin
            wreg(4'd3, 20'h0);
            wreg(4'd0, VECS[i].src);
            wreg(4'd1, VECS[i].dst);
            wreg(4'd2, 20'(VECS[i].rld));
            b_rd = nrd; b_wr = nwr; b_irq = irq0;
            wreg(4'd3, 20'(VECS[i].ctl));
            for (int k = 0; k < int'(VECS[i].nreq); k++) begin
                pulse(2'b01);
                idle(6);
            end
            chk($sformatf("R6 v%0d transfer count", i), 32'(nwr - b_wr), 32'(VECS[i].xfers));
            chk($sformatf("R2 v%0d reads match writes", i), 32'(nrd - b_rd), 32'(VECS[i].xfers));
            chk($sformatf("R4 v%0d last write addr", i), 32'(wr_log[nwr-1]), 32'(VECS[i].last_a));
            chk($sformatf("R3 v%0d last write data", i), 32'(wd_log[nwr-1]), 32'(VECS[i].last_d));
            rreg(4'd4, v); chk($sformatf("R6 R7 v%0d counter", i), 32'(v), 32'(VECS[i].cnt));
            rreg(4'd3, v); chk($sformatf("R6 R7 v%0d enable", i), 32'(v[0]), 32'(VECS[i].en));
            chk($sformatf("R8 v%0d irq cycles", i), 32'(irq0 - b_irq), 32'(VECS[i].irqs));
            chk($sformatf("R2 v%0d bus released", i), 32'(bus_req), 0);
        end

        // R5: both-forward control write discarded
        wreg(4'd3, 20'h05);
        wreg(4'd3, 20'h19);
        rreg(4'd3, v); chk("R5 both forward refused", 32'(v), 32'h05);
        wreg(4'd3, 20'h00);

        // R9: re-enable reloads forward pointer and counter
        wreg(4'd0, 20'h00300); wreg(4'd1, 20'h00060); wreg(4'd2, 20'd5);
        wreg(4'd3, 20'h09);
        pulse(2'b01); idle(6); pulse(2'b01); idle(6);
        chk("R4 second read addr", 32'(rd_log[nrd-1]), 32'h00301);
        wreg(4'd3, 20'h00); wreg(4'd3, 20'h09);
        pulse(2'b01); idle(6);
        chk("R9 read addr after re-enable", 32'(rd_log[nrd-1]), 32'h00300);
        rreg(4'd4, v); chk("R9 counter after re-enable", 32'(v), 32'd4);

        // R10: disabled channel 1 ignores its strobe
        wreg(4'd11, 20'h00);
        b_rd = nrd;
        pulse(2'b10); idle(8);
        chk("R10 no transfer when disabled", 32'(nrd - b_rd), 0);

        // R1: simultaneous requests, channel 0 first
        wreg(4'd8, 20'h00777); wreg(4'd9, 20'h00070); wreg(4'd10, 20'd9);
        wreg(4'd11, 20'h09);
        wreg(4'd3, 20'h00); wreg(4'd3, 20'h09);
        b_rd = nrd;
        pulse(2'b11); idle(12);
        chk("R1 two transfers", 32'(nrd - b_rd), 2);
        chk("R1 channel 0 first", 32'(rd_log[b_rd]), 32'h00300);
        chk("R1 channel 1 second", 32'(rd_log[b_rd+1]), 32'h00777);

        // R11: strobes during a stalled transfer merge into one
        b_rd = nrd;
        @(negedge clk); bus_gnt = 1'b0;
        pulse(2'b01); idle(2);
        pulse(2'b01); pulse(2'b01); idle(2);
        @(negedge clk); bus_gnt = 1'b1;
        idle(14);
        chk("R11 merged pending", 32'(nrd - b_rd), 2);

        summary();
    end
endmodule